// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block sits between the instruction fetch path and the data bus of an 8-bit processor. When the decoder presents an addressing mode together with the current index register value, the block collects the operand bytes that follow the opcode from a byte-wide program stream. It then forms the 16-bit effective address for the operand access.

It supports four modes. Direct and indexed-without-offset addresses stay in the first 256 bytes, because the high byte is forced to zero. Extended mode reaches the whole 64 KiB space. Indexed-with-8-bit-offset mode adds two unsigned bytes, and the carry goes into bit 8, so it reaches 0x0000 to 0x01FE.

The result comes out as a one-cycle strobe. The strobe carries the address and the total instruction length in bytes, counting the opcode. Requests and operand bytes each use a valid/ready handshake, and each handshake accepts at most one item per clock.

Top module: `ea_sequencer`

## Requirements
- R1: After synchronous reset, `ea_valid` is 0, `req_ready` is 1 and `byte_ready` is 0.
- R2: Mode code 2'b00 (direct) takes one operand byte B and produces `ea_addr` = {8'h00, B} with `ea_len` = 2.
- R3: Mode code 2'b01 (extended) takes two operand bytes. The first byte taken is the high address byte and the second is the low byte. `ea_len` = 3.
- R4: Mode code 2'b10 (indexed, no offset) takes no operand byte. It produces `ea_addr` = {8'h00, X} with `ea_len` = 1, and `ea_valid` rises in the cycle right after the request is accepted.
- R5: Mode code 2'b11 (indexed, 8-bit offset) takes one byte B and produces `ea_addr` = X + B as a 9-bit unsigned sum, with the carry in bit 8 and a maximum of 0x01FE. `ea_len` = 2.
- R6: In both indexed modes, bits 15 to 9 of `ea_addr` are zero whenever `ea_valid` is 1.
- R7: `ea_valid` is high for exactly one cycle. That cycle is the one right after the last required operand byte is taken, or right after the request for mode 2'b10.
- R8: The index value X is the one on `req_index` when the request is accepted. Later changes to `req_index` do not alter that address.
- R9: `req_ready` is 0 from request acceptance through the strobe cycle. Requests presented in that window are not taken and produce no strobe.
- R10: `byte_ready` is 1 only while operand bytes are still owed. Bytes offered at other times are not taken, and gaps in `byte_valid` only delay the strobe.
- R11: A synchronous reset during operand collection discards the bytes collected so far and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Addressing request present |
| req_mode | input | 2 | Mode code: 00 direct, 01 extended, 10 indexed no offset, 11 indexed 8-bit offset |
| req_index | input | 8 | Index register value, sampled on request acceptance |
| req_ready | output | 1 | Block is idle and accepts a request |
| byte_valid | input | 1 | Operand byte present on `byte_data` |
| byte_data | input | 8 | Operand byte from the program stream |
| byte_ready | output | 1 | Block accepts an operand byte this cycle |
| ea_valid | output | 1 | One-cycle effective address strobe |
| ea_addr | output | 16 | Effective address, meaningful while `ea_valid` is 1 |
| ea_len | output | 2 | Instruction length in bytes including the opcode, meaningful while `ea_valid` is 1 |

## Verification
The checker watches four things on every cycle. The strobe lasts a single cycle and always follows an operand byte or a no-offset request. The upper seven address bits stay clear in indexed modes. The two ready signals are never high together. A no-offset request turns into a length-1 strobe on the next edge.

The address values themselves can only be shown by the directed scenarios. These include byte order in extended mode, the carry into bit 8 and the 0x01FE ceiling, holding of the index across a change on `req_index`, ignored stray bytes and refused requests, stalls in the byte stream, and a reset in the middle of an instruction.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 2 * BYTE_W;
    localparam int MAX_OPERANDS = 2;
    localparam int CNT_W        = $clog2(MAX_OPERANDS + 1);
    localparam int LEN_W        = $clog2(MAX_OPERANDS + 2);
    localparam int IX_SUM_W     = BYTE_W + 1;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'b00,
        AM_EXTEND = 2'b01,
        AM_IDX0   = 2'b10,
        AM_IDX8   = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_COLLECT = 2'b01,
        ST_EMIT    = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } ea_result_t;

    // number of operand bytes that follow the opcode
    function automatic logic [CNT_W-1:0] operand_count(addr_mode_e m);
        case (m)
            AM_DIRECT: return CNT_W'(1);
            AM_EXTEND: return CNT_W'(2);
            AM_IDX0:   return CNT_W'(0);
            default:   return CNT_W'(1);
        endcase
    endfunction

    // total bytes of the instruction, opcode included
    function automatic logic [LEN_W-1:0] instr_length(addr_mode_e m);
        return LEN_W'(operand_count(m)) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  addr_mode_e       req_mode,
    input  logic             byte_valid,
    output logic             req_ready,
    output logic             byte_ready,
    output logic             take_req,
    output logic             take_byte,
    output logic [CNT_W-1:0] byte_sel,
    output logic             emit,
    output addr_mode_e       mode_q
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign byte_ready = (state_q == ST_COLLECT);
    assign take_req   = req_ready && req_valid;
    assign take_byte  = byte_ready && byte_valid;
    assign byte_sel   = cnt_q;
    assign emit       = (state_q == ST_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= AM_DIRECT;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take_req) begin
                        mode_q <= req_mode;
                        cnt_q  <= '0;
                        state_q <= (operand_count(req_mode) == '0) ? ST_EMIT : ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (take_byte) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if ((cnt_q + CNT_W'(1)) == operand_count(mode_q))
                            state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ea_operand_store.sv
module ea_operand_store
    import ea_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                take_req,
    input  logic [BYTE_W-1:0]                   req_index,
    input  logic                                take_byte,
    input  logic [CNT_W-1:0]                    byte_sel,
    input  logic [BYTE_W-1:0]                   byte_data,
    output logic [BYTE_W-1:0]                   index_q,
    output logic [MAX_OPERANDS-1:0][BYTE_W-1:0] ops_q
);

    always_ff @(posedge clk) begin
        if (rst)
            index_q <= '0;
        else if (take_req)
            index_q <= req_index;
    end

    for (genvar i = 0; i < MAX_OPERANDS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ops_q[i] <= '0;
            else if (take_byte && (byte_sel == CNT_W'(i)))
                ops_q[i] <= byte_data;
        end
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
(
    input  addr_mode_e                          mode,
    input  logic [BYTE_W-1:0]                   index,
    input  logic [MAX_OPERANDS-1:0][BYTE_W-1:0] ops,
    output ea_result_t                          result
);

    logic [IX_SUM_W-1:0] ix_sum;

    assign ix_sum = {1'b0, index} + {1'b0, ops[0]};

    always_comb begin
        result.len = instr_length(mode);
        case (mode)
            AM_DIRECT: result.addr = {{(ADDR_W-BYTE_W){1'b0}}, ops[0]};
            AM_EXTEND: result.addr = {ops[0], ops[1]};
            AM_IDX0:   result.addr = {{(ADDR_W-BYTE_W){1'b0}}, index};
            default:   result.addr = {{(ADDR_W-IX_SUM_W){1'b0}}, ix_sum};
        endcase
    end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_mode,
    input  logic [7:0]  req_index,
    output logic        req_ready,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        byte_ready,
    output logic        ea_valid,
    output logic [15:0] ea_addr,
    output logic [1:0]  ea_len
);

    logic                                take_req;
    logic                                take_byte;
    logic [CNT_W-1:0]                    byte_sel;
    logic                                emit;
    addr_mode_e                          mode_q;
    logic [BYTE_W-1:0]                   index_q;
    logic [MAX_OPERANDS-1:0][BYTE_W-1:0] ops_q;
    ea_result_t                          result;

    ea_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (addr_mode_e'(req_mode)),
        .byte_valid (byte_valid),
        .req_ready  (req_ready),
        .byte_ready (byte_ready),
        .take_req   (take_req),
        .take_byte  (take_byte),
        .byte_sel   (byte_sel),
        .emit       (emit),
        .mode_q     (mode_q)
    );

    ea_operand_store u_store (
        .clk       (clk),
        .rst       (rst),
        .take_req  (take_req),
        .req_index (req_index),
        .take_byte (take_byte),
        .byte_sel  (byte_sel),
        .byte_data (byte_data),
        .index_q   (index_q),
        .ops_q     (ops_q)
    );

    ea_addr_calc u_calc (
        .mode   (mode_q),
        .index  (index_q),
        .ops    (ops_q),
        .result (result)
    );

    assign ea_valid = emit;
    assign ea_addr  = result.addr;
    assign ea_len   = result.len;

endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_mode,
    input logic        req_ready,
    input logic        byte_valid,
    input logic        byte_ready,
    input logic        ea_valid,
    input logic [15:0] ea_addr,
    input logic [1:0]  ea_len,
    input logic [1:0]  mode_q
);

    // R7: strobe never lasts two cycles
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    // R7: strobe follows a taken byte or a no-offset request
    a_r7_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> ($past(byte_valid && byte_ready) ||
                      $past(req_valid && req_ready && req_mode == 2'b10)));

    // R6: upper bits clear in indexed modes
    a_r6_index_high_zero: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q[1]) |-> (ea_addr[15:9] == 7'd0));

    // R9 / R10: request and byte acceptance are exclusive
    a_r9_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && byte_ready));

    // R4: no-offset request strobes on the next edge with length 1
    a_r4_idx0_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mode == 2'b10) |=> (ea_valid && ea_len == 2'd1));

    // R9: no acceptance during the strobe cycle
    a_r9_busy_on_strobe: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (!req_ready && !byte_ready));

endmodule

bind ea_sequencer ea_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_ready  (req_ready),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .ea_valid   (ea_valid),
    .ea_addr    (ea_addr),
    .ea_len     (ea_len),
    .mode_q     (mode_q)
);

// File: tb/ea_sequencer_bench.sv
`timescale 1ns/1ps
module ea_sequencer_bench;

    localparam logic [1:0] M_DIR  = 2'b00;
    localparam logic [1:0] M_EXT  = 2'b01;
    localparam logic [1:0] M_IX0  = 2'b10;
    localparam logic [1:0] M_IX8  = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [7:0]  req_index = 8'h00;
    logic        req_ready;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_ready;
    logic        ea_valid;
    logic [15:0] ea_addr;
    logic [1:0]  ea_len;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ea_sequencer u_ea_sequencer (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_index  (req_index),
        .req_ready  (req_ready),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .ea_valid   (ea_valid),
        .ea_addr    (ea_addr),
        .ea_len     (ea_len)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // advance one edge; drives and samples happen 1 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        byte_valid = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic request(input logic [1:0] m, input logic [7:0] x);
        req_valid = 1'b1;
        req_mode  = m;
        req_index = x;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic give_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        tick();
        byte_valid = 1'b0;
    endtask

    task automatic expect_strobe(input string req, input logic [15:0] a, input logic [1:0] l);
        chk({req, " strobe"}, 32'(ea_valid), 32'd1);
        chk({req, " addr"}, 32'(ea_addr), 32'(a));
        chk({req, " len"}, 32'(ea_len), 32'(l));
        tick();
        chk({req, "/R7 strobe drop"}, 32'(ea_valid), 32'd0);
        chk({req, "/R1 back to idle"}, 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ea_valid", 32'(ea_valid), 32'd0);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 byte_ready", 32'(byte_ready), 32'd0);
    endtask

    task automatic t_direct();
        request(M_DIR, 8'h55);
        chk("R10 byte_ready while owed", 32'(byte_ready), 32'd1);
        give_byte(8'hA7);
        expect_strobe("R2 direct", 16'h00A7, 2'd2);
    endtask

    task automatic t_extended();
        request(M_EXT, 8'h00);
        give_byte(8'hC3);
        chk("R7 no strobe mid extended", 32'(ea_valid), 32'd0);
        give_byte(8'h1E);
        expect_strobe("R3 extended", 16'hC31E, 2'd3);
        request(M_EXT, 8'h00);
        give_byte(8'hFF);
        give_byte(8'hFF);
        expect_strobe("R3 extended top", 16'hFFFF, 2'd3);
    endtask

    task automatic t_idx0();
        request(M_IX0, 8'hFF);
        expect_strobe("R4 idx0", 16'h00FF, 2'd1);
        request(M_IX0, 8'h00);
        expect_strobe("R4 idx0 zero", 16'h0000, 2'd1);
    endtask

    task automatic t_idx8();
        request(M_IX8, 8'hFF);
        give_byte(8'hFF);
        expect_strobe("R5/R6 idx8 max", 16'h01FE, 2'd2);
        request(M_IX8, 8'h80);
        give_byte(8'h80);
        expect_strobe("R5 idx8 carry", 16'h0100, 2'd2);
        request(M_IX8, 8'h12);
        give_byte(8'h34);
        expect_strobe("R5 idx8 no carry", 16'h0046, 2'd2);
    endtask

    task automatic t_index_hold();
        request(M_IX8, 8'h10);
        req_index = 8'hF0;
        tick();
        give_byte(8'h05);
        expect_strobe("R8 index held", 16'h0015, 2'd2);
        request(M_IX0, 8'h3C);
        req_index = 8'h99;
        expect_strobe("R8 idx0 index held", 16'h003C, 2'd1);
    endtask

    task automatic t_busy_refuse();
        request(M_EXT, 8'h00);
        req_valid = 1'b1;
        req_mode  = M_IX0;
        req_index = 8'h77;
        chk("R9 req_ready low while collecting", 32'(req_ready), 32'd0);
        give_byte(8'h12);
        chk("R9 req_ready still low", 32'(req_ready), 32'd0);
        give_byte(8'h34);
        chk("R9 req_ready low on strobe", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        expect_strobe("R9 extended unaffected", 16'h1234, 2'd3);
        chk("R9 refused request gave no strobe", 32'(ea_valid), 32'd0);
    endtask

    task automatic t_stall_and_stray();
        byte_valid = 1'b1;
        byte_data  = 8'hEE;
        tick();
        chk("R10 stray byte not taken", 32'(byte_ready), 32'd0);
        chk("R10 stray byte no strobe", 32'(ea_valid), 32'd0);
        byte_valid = 1'b0;
        request(M_DIR, 8'h00);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10 stall no strobe", 32'(ea_valid), 32'd0);
            chk("R10 stall byte_ready", 32'(byte_ready), 32'd1);
        end
        give_byte(8'h42);
        expect_strobe("R10 direct after stall", 16'h0042, 2'd2);
    endtask

    task automatic t_reset_mid();
        request(M_EXT, 8'h00);
        give_byte(8'hAB);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11 idle after reset", 32'(req_ready), 32'd1);
        chk("R11 byte_ready cleared", 32'(byte_ready), 32'd0);
        chk("R11 no strobe", 32'(ea_valid), 32'd0);
        request(M_EXT, 8'h00);
        give_byte(8'h5A);
        chk("R11 partial byte dropped", 32'(ea_valid), 32'd0);
        give_byte(8'hC0);
        expect_strobe("R11 fresh extended", 16'h5AC0, 2'd3);
    endtask

    initial begin
        #1;
        t_reset();
        t_direct();
        t_extended();
        t_idx0();
        t_idx8();
        t_index_hold();
        t_busy_refuse();
        t_stall_and_stray();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule